// File: doc/BRIEF.md
# RGB Fast-Switch Insertion Controller

This block decides, pixel by pixel, whether the colour-difference stream leaving a video decoder carries the UV samples decoded from the composite or Y/C source, or UV samples matrixed from an RGB source on a peripheral connector. A fast-switch input from that connector marks where the RGB picture is to appear. The block trusts this input only after it has shown activity over two whole fields in a row. It then gates it into a fast-switch output that is confined to a window slightly smaller than the visible picture.

Where the selection changes, the block does not cut hard between sources. The two samples are mixed with a weight picked by the sub-pixel phase of the switch edge, so the edge lands between pixels. The block also produces a converter multiplexer select, which alternates U and V, two status bits and a flag that bypasses the chrominance stop filter in full-screen RGB operation. Line position, field position and the field boundary come from the timing generator as inputs.

Top module: `fsw_insert_ctrl`

## Requirements
- R1: While `rst_n` is low, `fs_out`, `uv_out`, `muxc`, `gp_stat` and `stop_bypass` are all 0.
- R2: In fast-insertion mode (`mode` = 2'b10), `gp_stat[0]` rises on the `field_start` edge that closes the second consecutive field in which the synchronised `fs_in` was seen high. Until then `fs_out` stays 0 and `uv_out` carries `uv_org`.
- R3: The window covers `h_pos` in [H_ACT*3/100, H_ACT-H_ACT*3/100) and `v_pos` in [V_ACT*3/100, V_ACT-V_ACT*3/100), which is [21,699) and [8,280) at the defaults. In qualified fast-insertion mode, `fs_out` is high exactly when the position sampled one clock earlier is inside the window and `fs_in` was high three clocks earlier.
- R4: A `field_start` that closes a field with no synchronised `fs_in` high clears the qualification and drops `gp_stat[0]`. After that, `fs_in` has no effect on `fs_out` or `uv_out` until two more qualifying fields have passed.
- R5: On the cycle the selection turns on, the inserted weight is (4-p)/4. On the cycle it turns off, the weight is p/4. Here p is `fs_phase` delayed like `fs_in`. In steady state the weight is 1 (selected) or 0 (not selected).
- R6: `uv_out` = floor((w*uv_ins + (4-w)*uv_org + 2)/4), with w the weight in quarters and both samples 8-bit two's complement. It is registered one clock after the samples.
- R7: In full-screen RGB mode (`mode` = 2'b01), `uv_out` carries `uv_ins` everywhere. `fs_out` follows the window alone and ignores `fs_in`. `stop_bypass` is 1.
- R8: `muxc` inverts on every clock in full-screen and fast-insertion modes and is 0 in normal mode.
- R9: In normal mode (`mode` = 2'b00 or 2'b11), `uv_out` equals `uv_org` of the previous clock, `fs_out` is 0 and `stop_bypass` is 0.
- R10: `gp_stat[1]` is 1 exactly when the selection that produced the current `uv_out` is the inserted source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00/11 normal, 01 full-screen RGB, 10 fast insertion |
| fs_in | input | 1 | Fast-switch input from the connector (asynchronous) |
| fs_phase | input | 2 | Sub-pixel phase of the fast-switch edge |
| field_start | input | 1 | One-clock pulse at each field boundary |
| h_pos | input | 11 | Pixel position within the active line |
| v_pos | input | 10 | Line position within the field |
| uv_org | input | 8 | Decoded UV sample, two's complement |
| uv_ins | input | 8 | RGB-derived UV sample, two's complement |
| fs_out | output | 1 | Gated fast-switch output |
| uv_out | output | 8 | Selected or blended UV sample |
| muxc | output | 1 | Converter U/V multiplexer select |
| gp_stat | output | 2 | [0] qualified, [1] inserted source active |
| stop_bypass | output | 1 | Bypass for the chrominance stop filter |

## Verification
The UV result is due one clock after its samples and window position are driven. The bench's driver queues each expected sample together with its inputs, and the monitor compares it 2 ns after the next rising edge. `fs_out` and `gp_stat[1]` also follow the window one clock later. A change on `fs_in` reaches them only after the two synchroniser stages, three clocks in all, so the bench holds `fs_in` steady for several cycles before it checks window effects. Qualification changes on the `field_start` edge itself, and the status bit is checked at the falling edge right after it.

// File: rtl/fsw_insert_ctrl.sv
module fsw_insert_ctrl #(
  parameter int H_W      = 11,
  parameter int V_W      = 10,
  parameter int D_W      = 8,
  parameter int H_ACT    = 720,
  parameter int V_ACT    = 288,
  parameter int MARG_PCT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic           fs_in,
  input  logic [1:0]     fs_phase,
  input  logic           field_start,
  input  logic [H_W-1:0] h_pos,
  input  logic [V_W-1:0] v_pos,
  input  logic [D_W-1:0] uv_org,
  input  logic [D_W-1:0] uv_ins,
  output logic           fs_out,
  output logic [D_W-1:0] uv_out,
  output logic           muxc,
  output logic [1:0]     gp_stat,
  output logic           stop_bypass
);
  localparam logic [H_W-1:0] H_LO = H_W'(H_ACT * MARG_PCT / 100);
  localparam logic [H_W-1:0] H_HI = H_W'(H_ACT - H_ACT * MARG_PCT / 100);
  localparam logic [V_W-1:0] V_LO = V_W'(V_ACT * MARG_PCT / 100);
  localparam logic [V_W-1:0] V_HI = V_W'(V_ACT - V_ACT * MARG_PCT / 100);
  localparam int ACC_W = D_W + 4;

  logic       s1, s2;
  logic [1:0] ph1, ph2;
  logic       fs_seen;
  logic [1:0] cnt;
  logic       sel_q;
  logic [2:0] w;

  wire is_full = (mode == 2'b01);
  wire is_fast = (mode == 2'b10);
  wire qual    = (cnt == 2'd2);
  wire in_win  = (h_pos >= H_LO) && (h_pos < H_HI) && (v_pos >= V_LO) && (v_pos < V_HI);
  wire gate    = is_fast && qual && s2 && in_win;
  wire sel     = is_full || gate;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; ph1 <= '0; ph2 <= '0;
    end else begin
      s1 <= fs_in; s2 <= s1; ph1 <= fs_phase; ph2 <= ph1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_seen <= 1'b0;
      cnt     <= '0;
    end else if (field_start) begin
      fs_seen <= 1'b0;
      if (fs_seen || s2) cnt <= qual ? cnt : cnt + 2'd1;
      else               cnt <= '0;
    end else if (s2) begin
      fs_seen <= 1'b1;
    end

  always_comb
    if (sel && !sel_q)      w = 3'd4 - {1'b0, ph2};
    else if (!sel && sel_q) w = {1'b0, ph2};
    else                    w = sel ? 3'd4 : 3'd0;

  logic signed [ACC_W-1:0] ie, oe, we, wc, acc;
  always_comb begin
    ie  = ACC_W'($signed(uv_ins));
    oe  = ACC_W'($signed(uv_org));
    we  = $signed({{(ACC_W-3){1'b0}}, w});
    wc  = ACC_W'(4) - we;
    acc = ie * we + oe * wc + ACC_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= 1'b0;
      uv_out <= '0;
      fs_out <= 1'b0;
      muxc   <= 1'b0;
    end else begin
      sel_q  <= sel;
      uv_out <= acc[D_W+1:2];
      fs_out <= is_full ? in_win : gate;
      muxc   <= (is_full || is_fast) ? !muxc : 1'b0;
    end

  assign gp_stat     = rst_n ? {sel_q, qual} : 2'b00;
  assign stop_bypass = rst_n && is_full;

  p_fso_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> ($past(h_pos) >= H_LO && $past(h_pos) < H_HI &&
                $past(v_pos) >= V_LO && $past(v_pos) < V_HI));

  p_fast_needs_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_out && $past(mode) == 2'b10) |-> $past(cnt) == 2'd2);

  p_empty_field_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !fs_seen && !s2) |=> !gp_stat[0]);

  p_normal_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(mode) == 2'b00 || $past(mode) == 2'b11)) |->
      (uv_out == $past(uv_org) && !fs_out));

  p_muxc_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(mode) == 2'b01 || $past(mode) == 2'b10)) |->
      (muxc != $past(muxc)));

  p_full_screen_ins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(mode) == 2'b01 && $past(mode, 2) == 2'b01) |->
      uv_out == $past(uv_ins));
endmodule

// File: tb/tb_fsw_insert_ctrl.sv
module tb_fsw_insert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        fs_in = 1'b0;
  logic [1:0]  fs_phase = 2'd0;
  logic        field_start = 1'b0;
  logic [10:0] h_pos = 11'd100;
  logic [9:0]  v_pos = 10'd100;
  logic [7:0]  uv_org = 8'd0;
  logic [7:0]  uv_ins = 8'd0;
  logic        fs_out, muxc, stop_bypass;
  logic [7:0]  uv_out;
  logic [1:0]  gp_stat;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { int exp; string tag; } item_t;
  item_t sb[$];

  fsw_insert_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fs_in(fs_in), .fs_phase(fs_phase),
    .field_start(field_start), .h_pos(h_pos), .v_pos(v_pos),
    .uv_org(uv_org), .uv_ins(uv_ins), .fs_out(fs_out), .uv_out(uv_out),
    .muxc(muxc), .gp_stat(gp_stat), .stop_bypass(stop_bypass));

  always #10 clk = ~clk;

  function automatic int mixv(int wq, int o, int i);
    int v = wq * i + (4 - wq) * o + 2;
    return v >>> 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pix(int h, int o, int i, int e, string tag);
    item_t it;
    @(negedge clk);
    h_pos = 11'(h); uv_org = 8'(o); uv_ins = 8'(i);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic field_pulse();
    @(negedge clk); field_start = 1'b1;
    @(negedge clk); field_start = 1'b0;
  endtask

  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk(it.tag, int'($signed(uv_out)), it.exp);
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int m0;
    cyc(3);
    chk("R1 fs_out", fs_out, 0); chk("R1 uv_out", uv_out, 0);
    chk("R1 muxc", muxc, 0); chk("R1 gp_stat", gp_stat, 0);
    chk("R1 stop_bypass", stop_bypass, 0);
    rst_n = 1'b1;

    // R9 normal mode with fs active
    fs_in = 1'b1; cyc(4);
    pix(100, 17, -50, 17, "R9 pass a");
    pix(100, -128, 127, -128, "R9 pass b");
    pix(100, 127, 0, 127, "R9 pass c");
    cyc(1);
    chk("R9 fs_out", fs_out, 0); chk("R9 stop_bypass", stop_bypass, 0);
    chk("R8 muxc normal", muxc, 0); cyc(1); chk("R8 muxc normal 2", muxc, 0);

    // R2 qualification
    mode = 2'b10; cyc(3);
    chk("R2 not yet", gp_stat[0], 0); chk("R2 fs_out off", fs_out, 0);
    pix(100, 9, 90, 9, "R2 original before qual");
    field_pulse(); chk("R2 one field", gp_stat[0], 0);
    pix(100, 9, 90, 9, "R2 original after one field");
    field_pulse(); chk("R2 two fields", gp_stat[0], 1);
    cyc(2);
    chk("R2 fs_out on", fs_out, 1); chk("R10 active", gp_stat[1], 1);
    pix(100, 9, 90, 90, "R2 inserted");
    m0 = muxc; cyc(1); chk("R8 muxc toggles fast", muxc, m0 ^ 1);

    // R3 window edges, phase 0
    pix(20, 1, 2, 1, "R3 h below"); cyc(1); chk("R3 fs h=20", fs_out, 0); chk("R10 off", gp_stat[1], 0);
    pix(21, 1, 2, 2, "R3 h low edge"); cyc(1); chk("R3 fs h=21", fs_out, 1);
    pix(698, 1, 2, 2, "R3 h high edge"); cyc(1); chk("R3 fs h=698", fs_out, 1);
    pix(699, 1, 2, 1, "R3 h above"); cyc(1); chk("R3 fs h=699", fs_out, 0);
    @(negedge clk); v_pos = 10'd7; h_pos = 11'd100; cyc(1); chk("R3 fs v=7", fs_out, 0);
    @(negedge clk); v_pos = 10'd8; cyc(1); chk("R3 fs v=8", fs_out, 1);
    @(negedge clk); v_pos = 10'd279; cyc(1); chk("R3 fs v=279", fs_out, 1);
    @(negedge clk); v_pos = 10'd280; cyc(1); chk("R3 fs v=280", fs_out, 0);
    @(negedge clk); v_pos = 10'd100;
    @(negedge clk); fs_in = 1'b0; cyc(3); chk("R3 fs_in latency low", fs_out, 0);
    @(negedge clk); fs_in = 1'b1;
    cyc(2); chk("R3 fs_in two clocks", fs_out, 0);
    cyc(1); chk("R3 fs_in three clocks", fs_out, 1);

    // R5 / R6 blending
    for (int p = 1; p < 4; p++) begin
      @(negedge clk); fs_phase = 2'(p); h_pos = 11'd10; cyc(3);
      pix(10, -20, 100, -20, "R5 steady out");
      pix(100, -20, 100, mixv(4 - p, -20, 100), "R5 rising blend");
      pix(100, -20, 100, 100, "R5 steady in");
      pix(10, -20, 100, mixv(p, -20, 100), "R5 falling blend");
    end
    @(negedge clk); fs_phase = 2'd2; cyc(3);
    pix(10, 0, -3, 0, "R6 prep");
    pix(100, 0, -3, mixv(2, 0, -3), "R6 negative rounding");
    pix(100, 5, -6, -6, "R6 steady");
    pix(10, 5, -6, mixv(2, 5, -6), "R6 half rounding");
    @(negedge clk); fs_phase = 2'd0; cyc(3);

    // R4 disqualification
    fs_in = 1'b0; cyc(4);
    field_pulse(); chk("R4 field with pulses keeps", gp_stat[0], 1);
    field_pulse(); chk("R4 empty field drops", gp_stat[0], 0);
    fs_in = 1'b1; cyc(5);
    chk("R4 fs_in ignored", fs_out, 0);
    pix(100, 33, 44, 33, "R4 original kept");
    fs_in = 1'b0; cyc(4);
    field_pulse(); field_pulse(); chk("R4 reset again", gp_stat[0], 0);
    fs_in = 1'b1; cyc(4);
    field_pulse(); chk("R2 single field after break", gp_stat[0], 0);
    field_pulse(); chk("R2 requalified", gp_stat[0], 1);

    // R7 full-screen
    @(negedge clk); mode = 2'b01; fs_in = 1'b0; cyc(4);
    chk("R7 fs_out window", fs_out, 1); chk("R7 stop_bypass", stop_bypass, 1);
    chk("R10 full active", gp_stat[1], 1);
    m0 = muxc; cyc(1); chk("R8 muxc toggles full", muxc, m0 ^ 1);
    pix(100, 5, -7, -7, "R7 inserted in window");
    pix(10, 5, -7, -7, "R7 inserted outside window");
    cyc(1); chk("R7 fs_out outside", fs_out, 0);

    // R9 mode 3
    @(negedge clk); mode = 2'b11; h_pos = 11'd100; cyc(3);
    pix(100, -77, 66, -77, "R9 mode3 pass");
    cyc(1);
    chk("R9 mode3 fs_out", fs_out, 0); chk("R9 mode3 bypass", stop_bypass, 0);
    chk("R8 muxc mode3", muxc, 0);
    cyc(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule